// File: doc/BRIEF.md
# Audio Sample Rate Mode Detector

This block watches the frame-rate clock of an incoming serial audio stream and decides which of three speed modes the stream belongs to: single, double or quad. It measures the distance between successive rising edges of the frame clock in cycles of a known reference clock. It then compares that count against cycle-count windows derived from a reference-frequency parameter.

A two-bit mode-select input either leaves the choice to automatic detection or forces one mode. A forced mode still has its measured rate checked against that mode's range. A standalone strap forces automatic detection whatever the mode-select input holds.

A classification is committed only after three consecutive frame periods agree. Until then the valid flag stays low. An out-of-range flag reports unsupported rates and a stopped frame clock.

Top module: `rate_mode_detect`

## Requirements
All rates below are expressed as a period P in reference-clock cycles, measured between successive synchronized rising edges of `lrckIn`. REF is the parameter `REF_HZ`. Output code `speedMode` is 00 for none, 01 for single, 10 for double and 11 for quad.
- R1: With automatic detection, a period with REF/50000 <= P <= REF/4000 (50 kHz down to 4 kHz) is classified single speed (01).
- R2: With automatic detection, a period with REF/100000 <= P <= REF/84000 (100 kHz down to 84 kHz) is classified double speed (10).
- R3: With automatic detection, a period with REF/200000 <= P <= REF/170000 (200 kHz down to 170 kHz) is classified quad speed (11).
- R4: With automatic detection, any period outside those three windows sets `outOfRange` to 1 and `modeValid` to 0 on that period, while `speedMode` keeps the last committed code.
- R5: A mode-select value of 01, 10 or 11 forces single, double or quad speed respectively. The forced mode is committed when P lies in its range: REF/50000..REF/4000 for single, REF/100000..REF/50000 for double, REF/200000..REF/100000 for quad. A value of 00 selects automatic detection.
- R6: In a forced mode, a period outside the forced mode's range sets `outOfRange` to 1 and `modeValid` to 0.
- R7: While `standalone` is 1, the mode-select input is ignored and automatic detection is used.
- R8: If no rising edge of the frame clock is seen for REF/3200 reference cycles, `modeValid` goes to 0 and `outOfRange` to 1.
- R9: A mode is committed, with `modeValid` = 1 and `outOfRange` = 0, only on the third consecutive in-range period with the same classification. A period classified differently drops `modeValid` at once. `speedMode` changes only at a commit.
- R10: The period count saturates instead of wrapping, so the first period measured after a stopped frame clock is reported out of range.
- R11: After reset, `speedMode` = 00, `modeValid` = 0 and `outOfRange` = 0. The first rising edge after reset only starts measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of frequency REF_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| lrckIn | input | 1 | Frame-rate clock of the audio stream, asynchronous |
| modeSel | input | 2 | 00 automatic, 01/10/11 force single/double/quad |
| standalone | input | 1 | Strap; 1 forces automatic detection |
| speedMode | output | 2 | Committed mode: 00 none, 01 single, 10 double, 11 quad |
| modeValid | output | 1 | High once a mode is committed and still confirmed |
| outOfRange | output | 1 | Unsupported rate or stopped frame clock |

## Verification
The hardest state to reach is the saturated count. It needs a frame clock that stops for longer than the timeout and then restarts. This must happen while valid was previously high, so that the first restarted period has to be rejected and the commit must then count three fresh periods. The stimulus holds the frame clock low past the timeout, then resumes with three periods and then one more, checking the flags after each step. The rate-window edges are reached by driving periods exactly on and one cycle outside each cycle-count limit. The confirmation rule is exercised by changing the period after only two periods.

// File: rtl/rmd_pkg.sv
package rmd_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_DOUBLE = 2'b10,
    MODE_QUAD   = 2'b11
  } speed_e;

  // strobes and classification handed from the datapath to the control
  typedef struct packed {
    logic   periodDone;
    logic   timedOut;
    logic   inRange;
    speed_e mode;
  } meas_s;

endpackage

// File: rtl/rmd_measure.sv
module rmd_measure
  import rmd_pkg::*;
#(
  parameter int REF_HZ = 4_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lrckIn,
  input  logic [1:0] modeSel,
  input  logic       standalone,
  output meas_s      meas
);

  localparam int CNT_MAX = REF_HZ / 3200;
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] LIM_4K   = CW'(REF_HZ / 4000);
  localparam logic [CW-1:0] LIM_50K  = CW'(REF_HZ / 50000);
  localparam logic [CW-1:0] LIM_84K  = CW'(REF_HZ / 84000);
  localparam logic [CW-1:0] LIM_100K = CW'(REF_HZ / 100000);
  localparam logic [CW-1:0] LIM_170K = CW'(REF_HZ / 170000);
  localparam logic [CW-1:0] LIM_200K = CW'(REF_HZ / 200000);
  localparam logic [CW-1:0] LIM_TMO  = CW'(CNT_MAX);

  logic          syncA, syncB, syncC;
  logic          riseSeen;
  logic          armed;
  logic [CW-1:0] periodCnt;
  logic [1:0]    effSel;
  speed_e        cls;
  logic          clsOk;

  function automatic logic inWin(input logic [CW-1:0] val,
                                 input logic [CW-1:0] lo,
                                 input logic [CW-1:0] hi);
    return (val >= lo) && (val <= hi);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= lrckIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign riseSeen = syncB & ~syncC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      armed     <= 1'b0;
    end else if (riseSeen) begin
      periodCnt <= CW'(1);
      armed     <= 1'b1;
    end else if (periodCnt != LIM_TMO) begin
      periodCnt <= periodCnt + CW'(1);
    end
  end

  assign effSel = standalone ? 2'b00 : modeSel;

  always_comb begin
    cls   = MODE_NONE;
    clsOk = 1'b0;
    unique case (effSel)
      2'b00: begin
        if (inWin(periodCnt, LIM_50K, LIM_4K))        cls = MODE_SINGLE;
        else if (inWin(periodCnt, LIM_100K, LIM_84K)) cls = MODE_DOUBLE;
        else if (inWin(periodCnt, LIM_200K, LIM_170K)) cls = MODE_QUAD;
        clsOk = (cls != MODE_NONE);
      end
      2'b01: begin
        cls   = MODE_SINGLE;
        clsOk = inWin(periodCnt, LIM_50K, LIM_4K);
      end
      2'b10: begin
        cls   = MODE_DOUBLE;
        clsOk = inWin(periodCnt, LIM_100K, LIM_50K);
      end
      default: begin
        cls   = MODE_QUAD;
        clsOk = inWin(periodCnt, LIM_200K, LIM_100K);
      end
    endcase
  end

  assign meas.periodDone = riseSeen & armed;
  assign meas.timedOut   = (periodCnt == LIM_TMO);
  assign meas.inRange    = clsOk;
  assign meas.mode       = cls;

endmodule

// File: rtl/rmd_control.sv
module rmd_control
  import rmd_pkg::*;
#(
  parameter int CONFIRM = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  meas_s      meas,
  output logic [1:0] speedMode,
  output logic       modeValid,
  output logic       outOfRange
);

  localparam int SW = $clog2(CONFIRM + 1);

  logic [SW-1:0] streak;
  speed_e        lastMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streak     <= '0;
      lastMode   <= MODE_NONE;
      speedMode  <= MODE_NONE;
      modeValid  <= 1'b0;
      outOfRange <= 1'b0;
    end else if (meas.timedOut) begin
      streak     <= '0;
      modeValid  <= 1'b0;
      outOfRange <= 1'b1;
    end else if (meas.periodDone) begin
      if (!meas.inRange) begin
        streak     <= '0;
        modeValid  <= 1'b0;
        outOfRange <= 1'b1;
      end else if ((streak != '0) && (meas.mode == lastMode)) begin
        if (streak != SW'(CONFIRM)) streak <= streak + SW'(1);
        if (streak >= SW'(CONFIRM - 1)) begin
          modeValid  <= 1'b1;
          outOfRange <= 1'b0;
          speedMode  <= meas.mode;
        end
      end else begin
        streak    <= SW'(1);
        lastMode  <= meas.mode;
        modeValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rate_mode_detect.sv
module rate_mode_detect
  import rmd_pkg::*;
#(
  parameter int REF_HZ  = 4_000_000,
  parameter int CONFIRM = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lrckIn,
  input  logic [1:0] modeSel,
  input  logic       standalone,
  output logic [1:0] speedMode,
  output logic       modeValid,
  output logic       outOfRange
);

  meas_s measBus;

  rmd_measure #(.REF_HZ(REF_HZ)) measure_i (
    .clk        (clk),
    .rstN       (rstN),
    .lrckIn     (lrckIn),
    .modeSel    (modeSel),
    .standalone (standalone),
    .meas       (measBus)
  );

  rmd_control #(.CONFIRM(CONFIRM)) control_i (
    .clk        (clk),
    .rstN       (rstN),
    .meas       (measBus),
    .speedMode  (speedMode),
    .modeValid  (modeValid),
    .outOfRange (outOfRange)
  );

endmodule

// File: rtl/rmd_checker.sv
module rmd_checker #(
  parameter int REF_HZ = 4_000_000
) (
  input logic       clk,
  input logic       rstN,
  input logic       lrckIn,
  input logic [1:0] speedMode,
  input logic       modeValid,
  input logic       outOfRange
);

  localparam int IDLE_LIM = REF_HZ / 3200 + 3;
  localparam int IW       = $clog2(IDLE_LIM + 1);

  logic          cA, cB, cC;
  logic [IW-1:0] idle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cA   <= 1'b0;
      cB   <= 1'b0;
      cC   <= 1'b0;
      idle <= '0;
    end else begin
      cA <= lrckIn;
      cB <= cA;
      cC <= cB;
      if (cB & ~cC)                 idle <= '0;
      else if (idle != IW'(IDLE_LIM)) idle <= idle + IW'(1);
    end
  end

  // R9
  valid_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> !outOfRange);

  // R5
  valid_has_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (speedMode != 2'b00));

  // R9
  mode_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(speedMode) |-> modeValid);

  // R8
  stall_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle == IW'(IDLE_LIM)) |-> (!modeValid && outOfRange));

endmodule

bind rate_mode_detect rmd_checker #(.REF_HZ(REF_HZ)) chk_i (.*);

// File: tb/rate_mode_detect_tb_top.sv
module rate_mode_detect_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 4_000_000;

  typedef struct {
    logic       valid;
    logic [1:0] mode;
    logic       oor;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lrckIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       standalone = 1'b0;
  logic [1:0] speedMode;
  logic       modeValid;
  logic       outOfRange;

  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;
  exp_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rate_mode_detect #(.REF_HZ(REF_HZ)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .lrckIn     (lrckIn),
    .modeSel    (modeSel),
    .standalone (standalone),
    .speedMode  (speedMode),
    .modeValid  (modeValid),
    .outOfRange (outOfRange)
  );

  task automatic expect_now(input logic v, input logic [1:0] m, input logic o,
                            input string tag);
    exp_t e;
    e.valid = v;
    e.mode  = m;
    e.oor   = o;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  // n rising edges, each followed by a full period of `per` cycles
  task automatic drive(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      lrckIn = 1'b1;
      repeat (per / 2) @(posedge clk);
      lrckIn = 1'b0;
      repeat (per - per / 2) @(posedge clk);
    end
  endtask

  task automatic step(input logic [1:0] sel, input logic strap, input int per,
                      input int n, input logic v, input logic [1:0] m,
                      input logic o, input string tag);
    modeSel    = sel;
    standalone = strap;
    drive(per, n);
    expect_now(v, m, o, tag);
  endtask

  // monitor: compares queued expectations on a falling edge
  initial begin
    exp_t e;
    forever begin
      wait (expQ.size() != 0);
      @(negedge clk);
      e = expQ.pop_front();
      total++;
      if (modeValid !== e.valid || speedMode !== e.mode || outOfRange !== e.oor) begin
        bad++;
        $display("FAIL %s: got valid=%b mode=%b oor=%b expected valid=%b mode=%b oor=%b",
                 e.tag, modeValid, speedMode, outOfRange, e.valid, e.mode, e.oor);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(posedge clk);
    expect_now(1'b0, 2'b00, 1'b0, "R11 reset state");
    // 250 cycles = 16 kHz; first edge only arms
    step(2'b00, 1'b0, 250, 5, 1'b1, 2'b01, 1'b0, "R1 auto 16k single");
    step(2'b00, 1'b0, 44, 2, 1'b0, 2'b01, 1'b0, "R9 change drops valid");
    step(2'b00, 1'b0, 44, 3, 1'b1, 2'b10, 1'b0, "R2 auto 91k double");
    step(2'b00, 1'b0, 22, 5, 1'b1, 2'b11, 1'b0, "R3 auto 182k quad");
    step(2'b00, 1'b0, 60, 5, 1'b0, 2'b11, 1'b1, "R4 auto gap 67k");
    step(2'b00, 1'b0, 30, 5, 1'b0, 2'b11, 1'b1, "R4 auto gap 133k");
    step(2'b10, 1'b0, 60, 5, 1'b1, 2'b10, 1'b0, "R5 forced double 67k");
    step(2'b10, 1'b0, 100, 5, 1'b0, 2'b10, 1'b1, "R6 forced double at 40k");
    step(2'b11, 1'b0, 30, 5, 1'b1, 2'b11, 1'b0, "R5 forced quad 133k");
    step(2'b01, 1'b0, 70, 5, 1'b0, 2'b11, 1'b1, "R6 forced single at 57k");
    step(2'b10, 1'b0, 80, 5, 1'b1, 2'b10, 1'b0, "R5 forced double edge 50k");
    step(2'b11, 1'b1, 30, 5, 1'b0, 2'b10, 1'b1, "R7 strap ignores quad force");
    step(2'b01, 1'b1, 44, 5, 1'b1, 2'b10, 1'b0, "R7 strap auto double");
    step(2'b00, 1'b0, 47, 5, 1'b1, 2'b10, 1'b0, "R2 edge 85.1k");
    step(2'b00, 1'b0, 48, 5, 1'b0, 2'b10, 1'b1, "R4 edge 83.3k");
    step(2'b00, 1'b0, 20, 5, 1'b1, 2'b11, 1'b0, "R3 edge 200k");
    step(2'b00, 1'b0, 19, 5, 1'b0, 2'b11, 1'b1, "R4 edge above 200k");
    step(2'b00, 1'b0, 24, 5, 1'b0, 2'b11, 1'b1, "R4 edge 166.7k");
    step(2'b00, 1'b0, 1000, 5, 1'b1, 2'b01, 1'b0, "R1 edge 4k");
    step(2'b00, 1'b0, 1001, 5, 1'b0, 2'b01, 1'b1, "R4 edge below 4k");
    step(2'b00, 1'b0, 80, 5, 1'b1, 2'b01, 1'b0, "R1 edge 50k");
    repeat (1400) @(posedge clk);
    expect_now(1'b0, 2'b01, 1'b1, "R8 stopped clock timeout");
    step(2'b00, 1'b0, 250, 3, 1'b0, 2'b01, 1'b1, "R10 saturated first period");
    step(2'b00, 1'b0, 250, 1, 1'b1, 2'b01, 1'b0, "R9 commit on third period");
    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule